// File: doc/BRIEF.md
# Dual-Pot Data Register Bank and Transfer Engine

This block keeps a small bank of stored wiper settings for two digitally controlled potentiometers. There are four 6-bit slots per pot. The block carries out every transfer between those slots and the wiper counters. A bus front end decodes each frame. When the frame ends with a stop condition, the front end presents the decoded command for one clock together with the pot index, the slot index and the data byte. The block then does one of the following:

- writes a slot from the host;
- copies one slot into a wiper counter, or copies a wiper counter into one slot;
- does either copy on both pots at once, using the same slot index for each.

The wiper counters live outside the block. This block only drives their parallel-load strobes and load values, and it reads their present values back on `wiper_cur`.

Any change to a stored slot stands for a nonvolatile program operation, so it starts a busy interval of `NV_CYCLES` clocks. While busy, the block refuses every command, and the front end polls `busy` to decide whether to acknowledge.

After reset the block first spends one cycle recalling slot 0 of each pot into its wiper counter. The controller has three states:

- `S_RECALL` is entered on reset and moves to `S_IDLE` unconditionally.
- `S_IDLE` moves to `S_PROGRAM` when it accepts a command that changes a slot, and otherwise stays.
- `S_PROGRAM` returns to `S_IDLE` in the cycle the program timer reaches its last count.

Top module: `dreg_xfer`

## Requirements
- R1: While reset is held and for the first cycle after it is released, slot r of pot p holds `INIT[(p*4+r)*6 +: 6]`. In that first cycle `busy` is 1, `wload` is 2'b11 and `wload_data` carries slot 0 of each pot (pot p in bits p*6+5..p*6). The next cycle `busy` is 0.
- R2: `cmd_op` 3'd1 (host write) with `cmd_acked` 1, taken in an idle cycle, stores `cmd_data` into slot `cmd_reg` of pot `cmd_pot`. The new value is visible on `rd_data` from the next cycle, and the write starts a busy interval.
- R3: A host write with `cmd_acked` 0 changes no slot and leaves `busy` at 0.
- R4: `cmd_op` 3'd2 (slot to wiper) asserts `wload` bit `cmd_pot` alone, in the same cycle as `cmd_stb`, with the selected slot on that pot's `wload_data` lane. It does not set `busy`.
- R5: `cmd_op` 3'd3 (wiper to slot) stores lane `cmd_pot` of `wiper_cur` into slot `cmd_reg` of that pot only, and starts a busy interval.
- R6: `cmd_op` 3'd4 (global slot to wiper) ignores `cmd_pot`. It asserts both `wload` bits with slot `cmd_reg` of each pot on its own lane, and does not set `busy`.
- R7: `cmd_op` 3'd5 (global wiper to slot) ignores `cmd_pot`. It stores each pot's `wiper_cur` lane into that pot's slot `cmd_reg`, and starts a busy interval.
- R8: A busy interval holds `busy` at 1 for exactly `NV_CYCLES` cycles after the clock edge that accepts the command.
- R9: While `busy` is 1, every command is ignored: no `wload` bit rises and no slot changes.
- R10: `cmd_op` values 3'd0, 3'd6 and 3'd7 do nothing: no load strobe, no slot change, no busy interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | One-cycle pulse: a decoded command ends with a stop condition |
| cmd_op | input | 3 | Command code |
| cmd_pot | input | 1 | Pot index (ignored by global commands) |
| cmd_reg | input | 2 | Slot index |
| cmd_data | input | 6 | Host data for a host write |
| cmd_acked | input | 1 | The data byte arrived complete and acknowledged |
| wiper_cur | input | 12 | Present wiper counter values, pot p in bits p*6+5..p*6 |
| rd_pot | input | 1 | Read pot index |
| rd_reg | input | 2 | Read slot index |
| rd_data | output | 6 | Contents of the addressed slot |
| wload | output | 2 | Per-pot wiper load strobe |
| wload_data | output | 12 | Wiper load values, pot p in bits p*6+5..p*6 |
| busy | output | 1 | Recall or program interval in progress; commands refused |

## Verification
The assertions assume the following about the inputs:

- `cmd_stb` is a single-cycle pulse, and the front end presents a command only at a stop condition.
- The command fields are stable in the cycle of `cmd_stb`.
- The only thing that changes a slot is an accepted command. This is what the property that `rd_data` holds while its address holds relies on.
- `busy` can be 1 after the first idle cycle only because a program interval is running.

The stimulus follows these rules. It drives every input one nanosecond after a rising edge and holds `cmd_stb` for exactly one cycle. Commands given inside a busy window are deliberate, and the bench expects nothing from them. The wiper values it feeds back come only from the load strobes the block itself produced.

// File: rtl/dreg_xfer_pkg.sv
package dreg_xfer_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_HOSTWR = 3'd1,
        OP_LOAD   = 3'd2,
        OP_SAVE   = 3'd3,
        OP_GLOAD  = 3'd4,
        OP_GSAVE  = 3'd5
    } xfer_op_e;

    typedef enum logic [1:0] {
        S_RECALL  = 2'd0,
        S_IDLE    = 2'd1,
        S_PROGRAM = 2'd2
    } bank_state_e;

endpackage

// File: rtl/dreg_prog_timer.sv
module dreg_prog_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // final count of the interval: the controller leaves programming here
    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/dreg_store.sv
module dreg_store #(
    parameter int NPOT = 2,
    parameter int NREG = 4,
    parameter int DW   = 6,
    parameter logic [NPOT*NREG*DW-1:0] INIT = '0,
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int PW = (NPOT > 1) ? $clog2(NPOT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPOT-1:0]    we,
    input  logic [IW-1:0]      widx,
    input  logic               use_host,
    input  logic [DW-1:0]      host_data,
    input  logic [NPOT*DW-1:0] wiper_data,
    input  logic [IW-1:0]      ld_idx,
    output logic [NPOT*DW-1:0] ld_data,
    input  logic [PW-1:0]      rd_pot,
    input  logic [IW-1:0]      rd_idx,
    output logic [DW-1:0]      rd_data
);
    logic [NPOT*DW-1:0] rd_flat;

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        logic [DW-1:0] slot_q [NREG];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int r = 0; r < NREG; r++)
                    slot_q[r] <= INIT[(p*NREG+r)*DW +: DW];
            end else if (we[p]) begin
                slot_q[widx] <= use_host ? host_data : wiper_data[p*DW +: DW];
            end
        end

        assign ld_data[p*DW +: DW] = slot_q[ld_idx];
        assign rd_flat[p*DW +: DW] = slot_q[rd_idx];
    end

    assign rd_data = rd_flat[rd_pot*DW +: DW];
endmodule

// File: rtl/dreg_ctrl.sv
module dreg_ctrl
    import dreg_xfer_pkg::*;
#(
    parameter int NPOT = 2,
    parameter int NREG = 4,
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int PW = (NPOT > 1) ? $clog2(NPOT) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_stb,
    input  logic [2:0]      cmd_op,
    input  logic [PW-1:0]   cmd_pot,
    input  logic [IW-1:0]   cmd_reg,
    input  logic            cmd_acked,
    input  logic            tmr_last,
    output logic [NPOT-1:0] we,
    output logic [IW-1:0]   widx,
    output logic            use_host,
    output logic [IW-1:0]   ld_idx,
    output logic [NPOT-1:0] wload,
    output logic            tmr_start,
    output logic            busy
);
    bank_state_e state_q, state_d;
    xfer_op_e    op;
    logic [NPOT-1:0] pot_mask;
    logic            changes_slot;

    assign op       = xfer_op_e'(cmd_op);
    assign pot_mask = NPOT'(1) << cmd_pot;
    assign changes_slot = cmd_stb &&
                          ((op == OP_HOSTWR && cmd_acked) ||
                           op == OP_SAVE || op == OP_GSAVE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RECALL;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RECALL:  state_d = S_IDLE;
            S_IDLE:    if (changes_slot) state_d = S_PROGRAM;
            S_PROGRAM: if (tmr_last)     state_d = S_IDLE;
            default:   state_d = S_RECALL;
        endcase
    end

    // outputs
    always_comb begin
        we        = '0;
        widx      = cmd_reg;
        use_host  = 1'b0;
        ld_idx    = cmd_reg;
        wload     = '0;
        tmr_start = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            S_RECALL: begin
                ld_idx = '0;
                wload  = '1;
            end
            S_IDLE: begin
                busy = 1'b0;
                if (cmd_stb) begin
                    case (op)
                        OP_HOSTWR: if (cmd_acked) begin
                            we        = pot_mask;
                            use_host  = 1'b1;
                            tmr_start = 1'b1;
                        end
                        OP_LOAD:  wload = pot_mask;
                        OP_SAVE: begin
                            we        = pot_mask;
                            tmr_start = 1'b1;
                        end
                        OP_GLOAD: wload = '1;
                        OP_GSAVE: begin
                            we        = '1;
                            tmr_start = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            S_PROGRAM: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/dreg_xfer.sv
module dreg_xfer #(
    parameter int NPOT      = 2,
    parameter int NREG      = 4,
    parameter int DW        = 6,
    parameter int NV_CYCLES = 20,
    parameter logic [NPOT*NREG*DW-1:0] INIT =
        {6'h1C, 6'h01, 6'h3E, 6'h2A, 6'h07, 6'h33, 6'h0A, 6'h15}
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       cmd_stb,
    input  logic [2:0]                                 cmd_op,
    input  logic [((NPOT > 1) ? $clog2(NPOT) : 1)-1:0] cmd_pot,
    input  logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] cmd_reg,
    input  logic [DW-1:0]                              cmd_data,
    input  logic                                       cmd_acked,
    input  logic [NPOT*DW-1:0]                         wiper_cur,
    input  logic [((NPOT > 1) ? $clog2(NPOT) : 1)-1:0] rd_pot,
    input  logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] rd_reg,
    output logic [DW-1:0]                              rd_data,
    output logic [NPOT-1:0]                            wload,
    output logic [NPOT*DW-1:0]                         wload_data,
    output logic                                       busy
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [NPOT-1:0] we;
    logic [IW-1:0]   widx;
    logic [IW-1:0]   ld_idx;
    logic            use_host;
    logic            tmr_start;
    logic            tmr_last;

    dreg_ctrl #(.NPOT(NPOT), .NREG(NREG)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_stb   (cmd_stb),
        .cmd_op    (cmd_op),
        .cmd_pot   (cmd_pot),
        .cmd_reg   (cmd_reg),
        .cmd_acked (cmd_acked),
        .tmr_last  (tmr_last),
        .we        (we),
        .widx      (widx),
        .use_host  (use_host),
        .ld_idx    (ld_idx),
        .wload     (wload),
        .tmr_start (tmr_start),
        .busy      (busy)
    );

    dreg_store #(.NPOT(NPOT), .NREG(NREG), .DW(DW), .INIT(INIT)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (we),
        .widx       (widx),
        .use_host   (use_host),
        .host_data  (cmd_data),
        .wiper_data (wiper_cur),
        .ld_idx     (ld_idx),
        .ld_data    (wload_data),
        .rd_pot     (rd_pot),
        .rd_idx     (rd_reg),
        .rd_data    (rd_data)
    );

    dreg_prog_timer #(.CYCLES(NV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .last  (tmr_last)
    );
endmodule

// File: rtl/dreg_xfer_chk.sv
module dreg_xfer_chk #(
    parameter int NPOT      = 2,
    parameter int NREG      = 4,
    parameter int DW        = 6,
    parameter int NV_CYCLES = 20,
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int PW = (NPOT > 1) ? $clog2(NPOT) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_stb,
    input logic [2:0]      cmd_op,
    input logic [PW-1:0]   cmd_pot,
    input logic [PW-1:0]   rd_pot,
    input logic [IW-1:0]   rd_reg,
    input logic [DW-1:0]   rd_data,
    input logic [NPOT-1:0] wload,
    input logic            busy
);
    logic seen_idle_q;
    int   run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_idle_q <= 1'b0;
            run_q       <= 0;
        end else begin
            if (!busy) seen_idle_q <= 1'b1;
            run_q <= busy ? run_q + 1 : 0;
        end
    end

    assert_recall_loads_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_idle_q && busy) |-> (wload == '1));

    assert_busy_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_stb));

    assert_slot_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |=> (!($stable(rd_pot) && $stable(rd_reg)) || $stable(rd_data)));

    assert_load_one_pot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_idle_q && !busy && cmd_stb && cmd_op == 3'd2) |-> (wload == (NPOT'(1) << cmd_pot)));

    assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_idle_q && !busy && run_q != 0) |-> (run_q == NV_CYCLES));

    assert_no_load_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_idle_q && busy) |-> (wload == '0));
endmodule

bind dreg_xfer dreg_xfer_chk #(
    .NPOT(NPOT), .NREG(NREG), .DW(DW), .NV_CYCLES(NV_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_stb (cmd_stb),
    .cmd_op  (cmd_op),
    .cmd_pot (cmd_pot),
    .rd_pot  (rd_pot),
    .rd_reg  (rd_reg),
    .rd_data (rd_data),
    .wload   (wload),
    .busy    (busy)
);

// File: tb/dreg_xfer_tb.sv
`timescale 1ns/100ps
module dreg_xfer_tb;
    localparam int NV = 20;
    localparam logic [47:0] INIT_V =
        {6'h1C, 6'h01, 6'h3E, 6'h2A, 6'h07, 6'h33, 6'h0A, 6'h15};

    typedef struct {
        logic [1:0]  mask;
        logic [11:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_stb = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic        cmd_pot = 1'b0;
    logic [1:0]  cmd_reg = '0;
    logic [5:0]  cmd_data = '0;
    logic        cmd_acked = 1'b0;
    logic [11:0] wiper_cur;
    logic        rd_pot = 1'b0;
    logic [1:0]  rd_reg = '0;
    logic [5:0]  rd_data;
    logic [1:0]  wload;
    logic [11:0] wload_data;
    logic        busy;

    logic [5:0]  wip0, wip1;
    logic [5:0]  exp_reg [2][4];
    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    dreg_xfer #(.NV_CYCLES(NV), .INIT(INIT_V)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
        .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
        .cmd_acked(cmd_acked), .wiper_cur(wiper_cur), .rd_pot(rd_pot),
        .rd_reg(rd_reg), .rd_data(rd_data), .wload(wload),
        .wload_data(wload_data), .busy(busy)
    );

    // wiper counter model fed only by the block's load strobes
    always @(posedge clk) begin
        if (!rst_n) begin
            wip0 <= '0;
            wip1 <= '0;
        end else begin
            if (wload[0]) wip0 <= wload_data[5:0];
            if (wload[1]) wip1 <= wload_data[11:6];
        end
    end
    assign wiper_cur = {wip1, wip0};

    // monitor: every load strobe must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && wload !== 2'b00) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected wiper load actual mask=%b expected none", wload);
            end else begin
                exp_t e;
                logic [11:0] m;
                e = q.pop_front();
                m = {{6{e.mask[1]}}, {6{e.mask[0]}}};
                if (wload !== e.mask || (wload_data & m) !== (e.data & m)) begin
                    errors++;
                    $display("FAIL %s wiper load actual mask=%b data=%h expected mask=%b data=%h",
                             e.tag, wload, wload_data & m, e.mask, e.data & m);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input string tag, input logic [1:0] mask, input logic [5:0] d1, input logic [5:0] d0);
        exp_t e;
        e.mask = mask;
        e.data = {d1, d0};
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic cmd(input logic [2:0] op, input logic pot, input logic [1:0] rg,
                       input logic [5:0] d, input logic ack);
        @(posedge clk); #1;
        cmd_stb = 1'b1; cmd_op = op; cmd_pot = pot; cmd_reg = rg;
        cmd_data = d; cmd_acked = ack;
        @(posedge clk); #1;
        cmd_stb = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic pot, input logic [1:0] rg);
        rd_pot = pot; rd_reg = rg;
        #1;
        chk(tag, 32'(rd_data), 32'(exp_reg[pot][rg]));
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy === 1'b1 && n < 1000) begin
            n++;
            @(posedge clk); #1;
        end
    endtask

    task automatic wait_idle();
        int n;
        busy_len(n);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < 4; r++)
                exp_reg[p][r] = INIT_V[(p*4+r)*6 +: 6];

        // R1: reset state and power-up recall
        push("R1", 2'b11, exp_reg[1][0], exp_reg[0][0]);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #0.5;
        chk("R1 busy during recall", 32'(busy), 32'd1);
        @(posedge clk); #1;
        chk("R1 busy after recall", 32'(busy), 32'd0);
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < 4; r++)
                rd_chk("R1 initial slot", p[0], r[1:0]);

        // R4: single-pot load, no busy
        push("R4", 2'b01, 6'h00, exp_reg[0][2]);
        cmd(3'd2, 1'b0, 2'd2, 6'h00, 1'b0);
        chk("R4 no busy", 32'(busy), 32'd0);
        push("R4", 2'b10, exp_reg[1][1], 6'h00);
        cmd(3'd2, 1'b1, 2'd1, 6'h00, 1'b0);
        chk("R4 no busy", 32'(busy), 32'd0);

        // R2 and R9: host write, then commands refused while busy
        cmd(3'd1, 1'b1, 2'd3, 6'h3C, 1'b1);
        exp_reg[1][3] = 6'h3C;
        chk("R2 busy started", 32'(busy), 32'd1);
        rd_chk("R2 new value", 1'b1, 2'd3);
        cmd(3'd2, 1'b1, 2'd3, 6'h00, 1'b0);
        cmd(3'd1, 1'b0, 2'd0, 6'h01, 1'b1);
        cmd(3'd4, 1'b0, 2'd0, 6'h00, 1'b0);
        wait_idle();
        rd_chk("R9 refused write", 1'b0, 2'd0);

        // R3: unacknowledged data byte
        cmd(3'd1, 1'b0, 2'd1, 6'h2F, 1'b0);
        chk("R3 no busy", 32'(busy), 32'd0);
        rd_chk("R3 slot unchanged", 1'b0, 2'd1);

        // R8: busy interval length
        cmd(3'd1, 1'b0, 2'd3, 6'h11, 1'b1);
        exp_reg[0][3] = 6'h11;
        busy_len(n);
        chk("R8 busy cycles", 32'(n), 32'(NV));
        rd_chk("R2 second write", 1'b0, 2'd3);

        // R5: wiper to slot on one pot
        cmd(3'd3, 1'b1, 2'd2, 6'h00, 1'b0);
        exp_reg[1][2] = wip1;
        chk("R5 busy started", 32'(busy), 32'd1);
        wait_idle();
        rd_chk("R5 saved slot", 1'b1, 2'd2);
        rd_chk("R5 other pot untouched", 1'b0, 2'd2);

        // R6: global slot to wiper, pot index ignored
        push("R6", 2'b11, exp_reg[1][3], exp_reg[0][3]);
        cmd(3'd4, 1'b0, 2'd3, 6'h00, 1'b0);
        chk("R6 no busy", 32'(busy), 32'd0);

        // R7: global wiper to slot, pot index ignored
        @(posedge clk); #1;
        cmd(3'd5, 1'b1, 2'd1, 6'h00, 1'b0);
        exp_reg[0][1] = wip0;
        exp_reg[1][1] = wip1;
        chk("R7 busy started", 32'(busy), 32'd1);
        wait_idle();
        rd_chk("R7 pot0 slot", 1'b0, 2'd1);
        rd_chk("R7 pot1 slot", 1'b1, 2'd1);
        chk("R7 value from wiper", 32'(exp_reg[0][1]), 32'h11);

        // R10: codes with no action
        cmd(3'd0, 1'b0, 2'd0, 6'h3F, 1'b1);
        chk("R10 nop no busy", 32'(busy), 32'd0);
        cmd(3'd6, 1'b1, 2'd0, 6'h3F, 1'b1);
        chk("R10 code6 no busy", 32'(busy), 32'd0);
        cmd(3'd7, 1'b0, 2'd0, 6'h3F, 1'b1);
        chk("R10 code7 no busy", 32'(busy), 32'd0);
        rd_chk("R10 slot unchanged", 1'b0, 2'd0);
        rd_chk("R10 slot unchanged", 1'b1, 2'd0);

        repeat (4) @(posedge clk);
        #1;
        chk("R4 scoreboard drained", 32'(q.size()), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule